// File: doc/BRIEF.md
# Multi-Channel Doorbell Interrupt Mailbox

This block lets processors signal one another through a small set of doorbell channels. Each channel keeps a 32-bit status word. Every bit stands for one kind of event. A sender raises a bit by writing a one to that channel's set register. The receiver handles the event, then drops the bit by writing a one to the clear register. Either side can read the status word at any time. Each channel drives one interrupt line, which is high whenever any bit of its word is high.

Two identical register ports are provided, one for each processor. Each port carries a valid, a write flag, a security attribute, a byte address and write data, and returns read data one cycle after the request. The highest-numbered channel is reserved for secure accesses. Non-secure masters cannot change that channel and read it back as zero.

Top module: `doorbell_mbox`

## Requirements
- R1: A synchronous active-low reset clears every status word and drives all `irq_o` bits and all `rsp_valid` bits low.
- R2: Register map: channel c occupies the 16-byte slot at byte address 16*c, so `req_addr[7:4]` selects the channel. `req_addr[3:2]` selects the register: 0 is status, 1 is set, 2 is clear and 3 is reserved. An access is ignored on write and reads back 0 if `req_addr[1:0]` is not 0, if the channel index is NUM_CH or more, or if it targets offset 3.
- R3: A write to the set register raises exactly the bits written as one. Bits written as zero keep their value, so a write of zero changes nothing. The new value is visible to a read issued on the next cycle.
- R4: A write to the clear register drops exactly the bits written as one and leaves all other bits unchanged.
- R5: A read request yields `rsp_valid` high for exactly one cycle, on the cycle after the request. `rsp_data` carries the status word as it stood when the request was sampled, before any write applied in that same cycle.
- R6: Writes to the status offset have no effect on the status word.
- R7: If a set and a clear hit the same bit in the same cycle, the bit ends up set. Sets and clears that arrive in the same cycle on both ports take effect together.
- R8: `irq_o[c]` is a registered output equal to the OR of channel c's status word. It rises or falls on the same clock edge that applies the write that changes the word.
- R9: The last channel (index NUM_CH-1) is secure-only. When `req_secure` is low, set and clear writes to it are ignored and reads of it return 0. Secure accesses behave as on any other channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NUM_PORTS | Request strobe, one bit per port |
| req_write | input | NUM_PORTS | 1 = write, 0 = read, per port |
| req_secure | input | NUM_PORTS | Security attribute of the access, per port |
| req_addr | input | NUM_PORTS x ADDR_W | Byte address, per port |
| req_wdata | input | NUM_PORTS x WORD_W | Write data (bit mask), per port |
| rsp_valid | output | NUM_PORTS | Read data valid, per port |
| rsp_data | output | NUM_PORTS x WORD_W | Read data, per port |
| irq_o | output | NUM_CH | Interrupt line of each channel |

## Verification
A set or clear presented before a rising edge changes the status word and the matching interrupt line at that edge. The bench therefore checks `irq_o` at the falling edge that follows. Read data and `rsp_valid` come one edge after the request. The driver queues the expected word, taken from a reference model before that cycle's writes are applied. The monitor pops and compares it 1 ns after the next rising edge, and any response with no pending entry fails. A clear that removes the last bit is checked to drop the interrupt at exactly that edge. A set and a clear issued in the same cycle on different ports are checked in a single step.

// File: rtl/dbm_pkg.sv
package dbm_pkg;

    // Word offset inside a channel slot (address bits [3:2])
    typedef enum logic [1:0] {
        SEL_STAT = 2'd0,
        SEL_SET  = 2'd1,
        SEL_CLR  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Low bit of the channel index in a byte address
    localparam int SLOT_LSB = 4;

endpackage

// File: rtl/dbm_port.sv
module dbm_port
    import dbm_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int WORD_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           valid,
    input  logic                           write,
    input  logic                           secure,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [WORD_W-1:0]              wdata,
    input  logic [NUM_CH-1:0][WORD_W-1:0]  status,
    output logic [NUM_CH-1:0][WORD_W-1:0]  set_mask,
    output logic [NUM_CH-1:0][WORD_W-1:0]  clr_mask,
    output logic                           rvalid,
    output logic [WORD_W-1:0]              rdata
);

    localparam int              CH_W    = ADDR_W - SLOT_LSB;
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] data;
    } rsp_t;

    rsp_t            rsp_d, rsp_q;
    logic [CH_W-1:0] ch;
    reg_sel_e        sel;
    logic            aligned;
    logic            allowed;

    always_comb begin
        ch       = addr[ADDR_W-1:SLOT_LSB];
        sel      = reg_sel_e'(addr[3:2]);
        aligned  = (addr[1:0] == 2'b00);
        // in range, word aligned, and secure if aimed at the last channel
        allowed  = valid && aligned && (ch <= LAST_CH) &&
                   ((ch != LAST_CH) || secure);
        set_mask = '0;
        clr_mask = '0;
        rsp_d    = '0;
        rsp_d.vld = valid && !write;
        for (int c = 0; c < NUM_CH; c++) begin
            if (allowed && (ch == CH_W'(c))) begin
                if (write && (sel == SEL_SET)) set_mask[c] = wdata;
                if (write && (sel == SEL_CLR)) clr_mask[c] = wdata;
                if (!write && (sel == SEL_STAT)) rsp_d.data = status[c];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rvalid = rsp_q.vld;
    assign rdata  = rsp_q.data;

endmodule

// File: rtl/dbm_channel.sv
module dbm_channel #(
    parameter int NUM_PORTS = 2,
    parameter int WORD_W    = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_PORTS-1:0][WORD_W-1:0]  set_vec,
    input  logic [NUM_PORTS-1:0][WORD_W-1:0]  clr_vec,
    output logic [WORD_W-1:0]                 status,
    output logic                              irq
);

    typedef struct packed {
        logic [WORD_W-1:0] stat;
        logic              irq;
    } ch_t;

    ch_t               ch_d, ch_q;
    logic [WORD_W-1:0] set_all;
    logic [WORD_W-1:0] clr_all;

    always_comb begin
        set_all = '0;
        clr_all = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            set_all = set_all | set_vec[p];
            clr_all = clr_all | clr_vec[p];
        end
        // clear first, then set: a same-cycle set survives
        ch_d.stat = (ch_q.stat & ~clr_all) | set_all;
        ch_d.irq  = |ch_d.stat;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign status = ch_q.stat;
    assign irq    = ch_q.irq;

endmodule

// File: rtl/doorbell_mbox.sv
module doorbell_mbox #(
    parameter int NUM_CH    = 3,
    parameter int NUM_PORTS = 2,
    parameter int WORD_W    = 32,
    parameter int ADDR_W    = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NUM_PORTS-1:0]                 req_valid,
    input  logic [NUM_PORTS-1:0]                 req_write,
    input  logic [NUM_PORTS-1:0]                 req_secure,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0]     req_addr,
    input  logic [NUM_PORTS-1:0][WORD_W-1:0]     req_wdata,
    output logic [NUM_PORTS-1:0]                 rsp_valid,
    output logic [NUM_PORTS-1:0][WORD_W-1:0]     rsp_data,
    output logic [NUM_CH-1:0]                    irq_o
);

    logic [NUM_CH-1:0][WORD_W-1:0]                 stat_w;
    logic [NUM_PORTS-1:0][NUM_CH-1:0][WORD_W-1:0]  set_pc, clr_pc;
    logic [NUM_CH-1:0][NUM_PORTS-1:0][WORD_W-1:0]  set_cp, clr_cp;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        dbm_port #(
            .NUM_CH (NUM_CH),
            .WORD_W (WORD_W),
            .ADDR_W (ADDR_W)
        ) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .valid    (req_valid[p]),
            .write    (req_write[p]),
            .secure   (req_secure[p]),
            .addr     (req_addr[p]),
            .wdata    (req_wdata[p]),
            .status   (stat_w),
            .set_mask (set_pc[p]),
            .clr_mask (clr_pc[p]),
            .rvalid   (rsp_valid[p]),
            .rdata    (rsp_data[p])
        );
    end

    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            for (int c = 0; c < NUM_CH; c++) begin
                set_cp[c][p] = set_pc[p][c];
                clr_cp[c][p] = clr_pc[p][c];
            end
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dbm_channel #(
            .NUM_PORTS (NUM_PORTS),
            .WORD_W    (WORD_W)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_vec (set_cp[c]),
            .clr_vec (clr_cp[c]),
            .status  (stat_w[c]),
            .irq     (irq_o[c])
        );
    end

endmodule

// File: rtl/dbm_checker.sv
module dbm_checker
    import dbm_pkg::*;
#(
    parameter int NUM_CH    = 3,
    parameter int NUM_PORTS = 2,
    parameter int WORD_W    = 32,
    parameter int ADDR_W    = 8
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic [NUM_PORTS-1:0]              req_valid,
    input logic [NUM_PORTS-1:0]              req_write,
    input logic [NUM_PORTS-1:0]              req_secure,
    input logic [NUM_PORTS-1:0][ADDR_W-1:0]  req_addr,
    input logic [NUM_PORTS-1:0][WORD_W-1:0]  req_wdata,
    input logic [NUM_PORTS-1:0]              rsp_valid,
    input logic [NUM_CH-1:0]                 irq_o,
    input logic [NUM_CH-1:0][WORD_W-1:0]     stat
);

    localparam int              CH_W    = ADDR_W - SLOT_LSB;
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    logic [NUM_PORTS-1:0]             wr_ok;
    logic [NUM_PORTS-1:0]             is_mod;
    logic [NUM_PORTS-1:0][NUM_CH-1:0] set_hit;
    logic                             any_mod;
    logic                             last_mod;

    always_comb begin
        any_mod  = 1'b0;
        last_mod = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            wr_ok[p] = req_valid[p] && req_write[p] && (req_addr[p][1:0] == 2'b00) &&
                       (req_addr[p][ADDR_W-1:SLOT_LSB] <= LAST_CH) &&
                       ((req_addr[p][ADDR_W-1:SLOT_LSB] != LAST_CH) || req_secure[p]);
            is_mod[p] = wr_ok[p] &&
                        ((reg_sel_e'(req_addr[p][3:2]) == SEL_SET) ||
                         (reg_sel_e'(req_addr[p][3:2]) == SEL_CLR));
            any_mod  = any_mod || (is_mod[p] && (req_wdata[p] != '0));
            last_mod = last_mod || (is_mod[p] && (req_addr[p][ADDR_W-1:SLOT_LSB] == LAST_CH));
            for (int c = 0; c < NUM_CH; c++) begin
                set_hit[p][c] = wr_ok[p] && (reg_sel_e'(req_addr[p][3:2]) == SEL_SET) &&
                                (req_addr[p][ADDR_W-1:SLOT_LSB] == CH_W'(c));
            end
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> ((irq_o == '0) && (rsp_valid == '0)));

    // R3
    no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_mod |=> $stable(stat));

    // R9
    secure_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !last_mod |=> $stable(stat[NUM_CH-1]));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_irq
        // R8
        irq_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[c] == (stat[c] != '0));
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
        // R5
        rsp_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[p] && !req_write[p]) |=> rsp_valid[p]);
        // R5
        rsp_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(req_valid[p] && !req_write[p]) |=> !rsp_valid[p]);
        for (genvar c = 0; c < NUM_CH; c++) begin : g_c
            // R7
            set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                set_hit[p][c] |=> ((stat[c] & $past(req_wdata[p])) == $past(req_wdata[p])));
        end
    end

endmodule

bind doorbell_mbox dbm_checker #(
    .NUM_CH    (NUM_CH),
    .NUM_PORTS (NUM_PORTS),
    .WORD_W    (WORD_W),
    .ADDR_W    (ADDR_W)
) u_dbm_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_secure (req_secure),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .irq_o      (irq_o),
    .stat       (stat_w)
);

// File: tb/doorbell_mbox_bench.sv
`timescale 1ns/1ps
module doorbell_mbox_bench;

    localparam int NCH = 3;
    localparam int NP  = 2;
    localparam int W   = 32;
    localparam int AW  = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                 rst_n;
    logic [NP-1:0]        req_valid, req_write, req_secure;
    logic [NP-1:0][AW-1:0] req_addr;
    logic [NP-1:0][W-1:0] req_wdata;
    logic [NP-1:0]        rsp_valid;
    logic [NP-1:0][W-1:0] rsp_data;
    logic [NCH-1:0]       irq_o;

    doorbell_mbox #(.NUM_CH(NCH), .NUM_PORTS(NP), .WORD_W(W), .ADDR_W(AW)) u_doorbell_mbox (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_secure(req_secure), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .irq_o(irq_o)
    );

    typedef struct {
        logic [W-1:0] data;
        string        tag;
    } exp_t;

    int           n_chk  = 0;
    int           n_fail = 0;
    logic [W-1:0] mdl [NCH];
    exp_t         q0[$];
    exp_t         q1[$];
    string        ptag [NP];

    task automatic chk(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // reference decode taken from the register map requirement
    function automatic bit acc_ok(int p);
        int ch = int'(req_addr[p][7:4]);
        return (req_addr[p][1:0] == 2'b00) && (ch < NCH) &&
               ((ch != NCH-1) || req_secure[p]);
    endfunction

    task automatic drv(int p, bit wr, bit sec, logic [AW-1:0] a, logic [W-1:0] d, string tag);
        req_valid[p]  = 1'b1;
        req_write[p]  = wr;
        req_secure[p] = sec;
        req_addr[p]   = a;
        req_wdata[p]  = d;
        ptag[p]       = tag;
    endtask

    task automatic tick();
        logic [W-1:0] s_m [NCH];
        logic [W-1:0] c_m [NCH];
        for (int c = 0; c < NCH; c++) begin
            s_m[c] = '0;
            c_m[c] = '0;
        end
        for (int p = 0; p < NP; p++) begin
            if (req_valid[p]) begin
                int  ch  = int'(req_addr[p][7:4]);
                int  off = int'(req_addr[p][3:2]);
                bit  ok  = acc_ok(p);
                if (!req_write[p]) begin
                    exp_t e;
                    e.data = '0;
                    e.tag  = ptag[p];
                    if (ok && off == 0) e.data = mdl[ch];
                    if (p == 0) q0.push_back(e);
                    else        q1.push_back(e);
                end else if (ok) begin
                    if (off == 1) s_m[ch] = s_m[ch] | req_wdata[p];
                    if (off == 2) c_m[ch] = c_m[ch] | req_wdata[p];
                end
            end
        end
        @(negedge clk);
        for (int c = 0; c < NCH; c++) mdl[c] = (mdl[c] & ~c_m[c]) | s_m[c];
        req_valid = '0;
    endtask

    task automatic rd(int p, bit sec, logic [AW-1:0] a, string tag);
        drv(p, 1'b0, sec, a, '0, tag);
        tick();
    endtask

    task automatic wr(int p, bit sec, logic [AW-1:0] a, logic [W-1:0] d);
        drv(p, 1'b1, sec, a, d, "");
        tick();
    endtask

    task automatic chk_irq(string tag);
        for (int c = 0; c < NCH; c++)
            chk(irq_o[c] == (mdl[c] != '0), tag, W'(irq_o[c]), W'(mdl[c] != '0));
    endtask

    // monitor: pops the expected read word when a response appears
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n === 1'b1) begin
                for (int p = 0; p < NP; p++) begin
                    if (rsp_valid[p]) begin
                        exp_t e;
                        bit   have;
                        have = (p == 0) ? (q0.size() > 0) : (q1.size() > 0);
                        if (!have) begin
                            chk(1'b0, "R5 response without request", rsp_data[p], '0);
                        end else begin
                            e = (p == 0) ? q0.pop_front() : q1.pop_front();
                            chk(rsp_data[p] == e.data, e.tag, rsp_data[p], e.data);
                        end
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        req_valid  = '0;
        req_write  = '0;
        req_secure = '0;
        req_addr   = '0;
        req_wdata  = '0;
        for (int c = 0; c < NCH; c++) mdl[c] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(irq_o == '0, "R1 irq after reset", W'(irq_o), '0);
        chk(rsp_valid == '0, "R1 rsp_valid after reset", W'(rsp_valid), '0);
        for (int c = 0; c < NCH; c++) rd(0, 1'b1, AW'(16*c), "R1 status zero after reset");

        // R3 set bits, R8 irq rises on the applying edge
        wr(0, 1'b0, 8'h04, 32'h0000_0005);
        chk_irq("R8 irq rise ch0");
        rd(1, 1'b0, 8'h00, "R3 set 0x5");
        wr(0, 1'b0, 8'h04, 32'h8000_0000);
        rd(0, 1'b0, 8'h00, "R3 set keeps other bits");
        wr(0, 1'b0, 8'h04, 32'h0);
        wr(1, 1'b0, 8'h08, 32'h0);
        rd(0, 1'b0, 8'h00, "R3 zero writes change nothing");

        // R4 clear
        wr(1, 1'b0, 8'h08, 32'h0000_0004);
        rd(1, 1'b0, 8'h00, "R4 clear one bit");
        chk_irq("R8 irq stays with bits left");

        // R6 status offset write
        wr(0, 1'b1, 8'h00, 32'hFFFF_FFFF);
        rd(0, 1'b0, 8'h00, "R6 status write ignored");

        // R7 set wins against same-cycle clear
        drv(0, 1'b1, 1'b0, 8'h04, 32'h0000_0010, "");
        drv(1, 1'b1, 1'b0, 8'h08, 32'h8000_0011, "");
        tick();
        rd(0, 1'b0, 8'h00, "R7 set wins over clear");
        // R7 both ports set ch1 together
        drv(0, 1'b1, 1'b0, 8'h14, 32'h0000_0F00, "");
        drv(1, 1'b1, 1'b0, 8'h14, 32'h00F0_0000, "");
        tick();
        chk_irq("R8 irq ch1 dual set");
        // R5 both ports read in one cycle, data from before same-cycle write
        drv(0, 1'b0, 1'b0, 8'h10, '0, "R7 dual set combined p0");
        drv(1, 1'b0, 1'b0, 8'h10, '0, "R7 dual set combined p1");
        tick();
        drv(0, 1'b1, 1'b0, 8'h18, 32'h0000_0F00, "");
        drv(1, 1'b0, 1'b0, 8'h10, '0, "R5 read sees pre-write value");
        tick();
        rd(1, 1'b0, 8'h10, "R4 clear ch1 low byte group");

        // R8 irq falls on the edge that clears the last bit
        chk(irq_o[0] == 1'b1, "R8 irq ch0 high before clear", W'(irq_o[0]), 32'h1);
        wr(1, 1'b0, 8'h08, 32'hFFFF_FFFF);
        chk(irq_o[0] == 1'b0, "R8 irq ch0 falls at clear", W'(irq_o[0]), 32'h0);

        // R9 secure channel
        wr(0, 1'b0, 8'h24, 32'h0000_00FF);
        chk(irq_o[2] == 1'b0, "R9 non-secure set ignored", W'(irq_o[2]), 32'h0);
        rd(0, 1'b1, 8'h20, "R9 status after non-secure set");
        wr(0, 1'b1, 8'h24, 32'h0000_0300);
        chk_irq("R9 secure set raises irq");
        rd(1, 1'b0, 8'h20, "R9 non-secure read returns zero");
        rd(1, 1'b1, 8'h20, "R9 secure read");
        wr(1, 1'b0, 8'h28, 32'hFFFF_FFFF);
        rd(1, 1'b1, 8'h20, "R9 non-secure clear ignored");
        wr(1, 1'b1, 8'h28, 32'h0000_0100);
        rd(0, 1'b1, 8'h20, "R9 secure clear");

        // R2 map corners
        wr(0, 1'b0, 8'h15, 32'h0000_0001);
        rd(0, 1'b0, 8'h10, "R2 misaligned write ignored");
        rd(0, 1'b0, 8'h11, "R2 misaligned read zero");
        rd(0, 1'b0, 8'h1C, "R2 reserved offset reads zero");
        wr(0, 1'b1, 8'h34, 32'hFFFF_FFFF);
        rd(0, 1'b1, 8'h30, "R2 unmapped channel reads zero");
        chk_irq("R2 unmapped write touches nothing");

        // R1 mid-run reset
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < NCH; c++) mdl[c] = '0;
        chk(irq_o == '0, "R1 irq cleared by reset", W'(irq_o), '0);
        rd(0, 1'b1, 8'h10, "R1 ch1 zero after reset");
        rd(1, 1'b1, 8'h20, "R1 ch2 zero after reset");

        repeat (3) @(negedge clk);
        chk(q0.size() == 0, "R5 port0 responses all arrived", W'(q0.size()), '0);
        chk(q1.size() == 0, "R5 port1 responses all arrived", W'(q1.size()), '0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule